// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers interrupt requests from fifteen device lines and funnels them onto one request toward the processor. It is built from two identical eight-line units. The upper unit faces the processor; the lower unit's combined request feeds line 2 of the upper unit in place of a device. Each unit records rising edges on its lines as pending events and keeps them until they are serviced. A per-line mask stops a pending event from reaching the processor without discarding it, so the event is delivered as soon as the mask bit is cleared. This per-line masking is separate from any global interrupt enable inside the processor, which stays outside the block.

The processor sees the request as a valid/ready stream of 8-bit vectors. `irq_valid_o` high means an unmasked event is pending and `irq_vector_o` names the winner under a fixed priority. A transfer happens on a clock edge where valid and ready are both high; that transfer clears the winner's pending bit. Valid stays high until a transfer occurs or the software masks or clears every pending event. While ready is low, the vector does not change unless a line of higher priority becomes eligible. Software reaches both mask registers and both status registers through a small synchronous register port. Reads are combinational.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset both mask registers read 0xFF, so every line is masked. Both status registers read 0x00 and `irq_valid_o` is low.
- R2: A 0-to-1 change on a device line, sampled at a clock edge, sets bit n of that unit's status register at that same edge. The primary status register is at address 2 and the secondary at address 3, with bit n standing for line n. A line that is held high does not set the bit again after it has been cleared.
- R3: An event that arrives on a masked line stays pending and keeps `irq_valid_o` low. When that line's mask bit is cleared, `irq_valid_o` rises in the cycle after the write.
- R4: The primary mask is at address 0 and the secondary mask at address 1. Bit n set to 1 masks line n. Writes take effect at the clock edge and read back unchanged.
- R5: Priority is fixed and the lowest primary line number wins. The whole secondary unit takes the place of primary line 2, so it ranks below primary line 1 and above primary line 3. Inside the secondary unit the lowest line number wins.
- R6: The vector is 0x20 plus n for primary line n, and 0x28 plus m for secondary line m.
- R7: A transfer (valid and ready both high at an edge) clears the pending bit of the line that won, and the next winner is presented in the following cycle. While ready is low, valid and the vector stay unchanged.
- R8: The device pin for primary line 2 has no effect. Primary status bit 2 reads 1 whenever the secondary unit has an unmasked pending event. Primary mask bit 2 blocks all secondary requests.
- R9: Writing to a status address clears every pending bit written as 1 and leaves the bits written as 0 unchanged.
- R10: If a new rising edge and a clear for the same line fall in the same cycle, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_line_i | input | 8 | Primary device lines (bit 2 unused) |
| sec_line_i | input | 8 | Secondary device lines |
| reg_addr_i | input | 2 | Register select: 0 pri mask, 1 sec mask, 2 pri status, 3 sec status |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_valid_o | output | 1 | Request toward the processor / vector valid |
| irq_ready_i | input | 1 | Processor accepts the vector |
| irq_vector_o | output | 8 | Vector of the winning line |

## Verification
A lost or stuck pending bit appears at the status address in the cycle after the edge or the clear, and at `irq_valid_o` once the line is unmasked. A wrong priority or a wrong cascade mapping shows up directly as a wrong vector value, or as a wrong order of vectors across several back-to-back transfers. A clear that hits the wrong unit shows up one transfer later: a vector repeats, or a secondary line is served twice.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINES    = 8;
  localparam int unsigned IDX_W    = $clog2(LINES);
  localparam int unsigned CASC_IDX = 2;

  typedef enum logic [1:0] {
    RA_PRI_MASK = 2'd0,
    RA_SEC_MASK = 2'd1,
    RA_PRI_STAT = 2'd2,
    RA_SEC_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N   = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit #(
  parameter int unsigned N        = 8,
  parameter logic [N-1:0] LVL_MASK = '0,
  parameter logic [N-1:0] MASK_RST = '1,
  localparam int unsigned IW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  line_i,
  input  logic [N-1:0]  lvl_i,
  input  logic          mask_we_i,
  input  logic          stat_we_i,
  input  logic [N-1:0]  wdata_i,
  input  logic          clr_win_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  status_o,
  output logic          req_o,
  output logic [IW-1:0] win_o
);
  localparam logic [N-1:0] LATCH_MASK = ~LVL_MASK;

  logic [N-1:0] line_q, pend_q, mask_q;
  logic [N-1:0] rise, clr_vec, pend_d, active;

  assign rise    = line_i & ~line_q;
  assign clr_vec = (clr_win_i ? (N'(1) << win_o) : '0) | (stat_we_i ? wdata_i : '0);
  assign pend_d  = ((pend_q & ~clr_vec) | rise) & LATCH_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      line_q <= line_i;
      pend_q <= pend_d;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign status_o = (pend_q & LATCH_MASK) | (lvl_i & LVL_MASK);
  assign active   = status_o & ~mask_q;
  assign mask_o   = mask_q;

  irqc_prio #(.N(N)) u_prio (
    .req_i (active),
    .idx_o (win_o),
    .any_o (req_o)
  );

  a_r5_winner_is_active: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (active[win_o] && !mask_q[win_o]));

  for (genvar i = 0; i < N; i++) begin : g_line_chk
    if (LATCH_MASK[i]) begin : g_latched
      a_r2_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i[i] && !line_q[i]) |=> pend_q[i]);
      a_r3_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_vec[i]) |=> pend_q[i]);
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter logic [7:0] PRI_BASE = 8'h20,
  parameter logic [7:0] SEC_BASE = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pri_line_i,
  input  logic [7:0] sec_line_i,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_valid_o,
  input  logic       irq_ready_i,
  output logic [7:0] irq_vector_o
);
  import irqc_pkg::*;

  localparam logic [LINES-1:0] PRI_LVL = LINES'(1) << CASC_IDX;

  logic [LINES-1:0] p_mask, s_mask, p_stat, s_stat;
  logic             p_req, s_req, xfer, p_clr, s_clr, win_casc;
  logic [IDX_W-1:0] p_win, s_win;
  reg_addr_e        addr;

  assign addr     = reg_addr_e'(reg_addr_i);
  assign xfer     = irq_valid_o && irq_ready_i;
  assign win_casc = (p_win == IDX_W'(CASC_IDX));
  assign p_clr    = xfer && !win_casc;
  assign s_clr    = xfer && win_casc;

  irqc_unit #(.N(LINES), .LVL_MASK(PRI_LVL)) u_pri (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (pri_line_i),
    .lvl_i     ({{(LINES-1-CASC_IDX){1'b0}}, s_req, {CASC_IDX{1'b0}}}),
    .mask_we_i (reg_we_i && addr == RA_PRI_MASK),
    .stat_we_i (reg_we_i && addr == RA_PRI_STAT),
    .wdata_i   (reg_wdata_i),
    .clr_win_i (p_clr),
    .mask_o    (p_mask),
    .status_o  (p_stat),
    .req_o     (p_req),
    .win_o     (p_win)
  );

  irqc_unit #(.N(LINES), .LVL_MASK('0)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (sec_line_i),
    .lvl_i     ('0),
    .mask_we_i (reg_we_i && addr == RA_SEC_MASK),
    .stat_we_i (reg_we_i && addr == RA_SEC_STAT),
    .wdata_i   (reg_wdata_i),
    .clr_win_i (s_clr),
    .mask_o    (s_mask),
    .status_o  (s_stat),
    .req_o     (s_req),
    .win_o     (s_win)
  );

  always_comb begin
    unique case (addr)
      RA_PRI_MASK: reg_rdata_o = p_mask;
      RA_SEC_MASK: reg_rdata_o = s_mask;
      RA_PRI_STAT: reg_rdata_o = p_stat;
      default:     reg_rdata_o = s_stat;
    endcase
  end

  assign irq_valid_o  = p_req;
  assign irq_vector_o = win_casc ? (SEC_BASE + 8'(s_win)) : (PRI_BASE + 8'(p_win));

  a_r6_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vector_o >= PRI_BASE && irq_vector_o < SEC_BASE + 8'(LINES)
                     && irq_vector_o != PRI_BASE + 8'(CASC_IDX)));
  a_r7_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i && !reg_we_i && pri_line_i == 8'h00 && sec_line_i == 8'h00)
      |=> (irq_valid_o && $stable(irq_vector_o)));
  a_r8_cascade_needs_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && win_casc) |-> (s_req && !p_mask[CASC_IDX]));
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pri_line = '0, sec_line = '0, wdata = '0, rdata, vec;
  logic [1:0] addr = '0;
  logic       we = 1'b0, ready = 1'b0, valid;
  int         n_chk = 0, n_bad = 0;
  bit         summarized = 1'b0;

  always #5 clk = ~clk;

  irq_cascade_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pri_line_i(pri_line), .sec_line_i(sec_line),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_valid_o(valid), .irq_ready_i(ready), .irq_vector_o(vec)
  );

  // {pri lines, sec lines, pri mask, sec mask, 7'b0+exp valid, exp vector}
  localparam logic [47:0] TBL [10] = '{
    48'h01_00_00_00_01_20,  // R6 primary 0
    48'h88_00_00_00_01_23,  // R5 lowest primary wins
    48'h80_10_00_00_01_2C,  // R5 secondary above primary 7
    48'h02_01_00_00_01_21,  // R5 primary 1 above secondary
    48'h08_40_04_00_01_23,  // R8 primary mask bit 2 blocks secondary
    48'h00_30_00_10_01_2D,  // R4 secondary mask
    48'h04_00_00_00_00_00,  // R8 primary line 2 pin ignored
    48'h01_00_01_00_00_00,  // R3 masked line silent
    48'hFB_FF_FF_FF_00_00,  // R1 all masked
    48'h00_80_00_00_01_2F   // R6 secondary 7
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic xfer();
    ready = 1'b1; tick(); ready = 1'b0;
  endtask

  task automatic clean(input logic [7:0] pm, input logic [7:0] sm);
    pri_line = '0; sec_line = '0; tick();
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    wr(2'd0, pm); wr(2'd1, sm);
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R1 reset state
    rd_chk("R1 pri mask", 2'd0, 8'hFF);
    rd_chk("R1 sec mask", 2'd1, 8'hFF);
    rd_chk("R1 pri status", 2'd2, 8'h00);
    rd_chk("R1 sec status", 2'd3, 8'h00);
    chk("R1 valid", {7'b0, valid}, 8'h00);

    // R3 masked event held, released on unmask
    pri_line = 8'h20; tick();
    chk("R3 valid while masked", {7'b0, valid}, 8'h00);
    rd_chk("R2 status set by edge", 2'd2, 8'h20);
    wr(2'd0, 8'hDF);
    chk("R3 valid after unmask", {7'b0, valid}, 8'h01);
    chk("R6 vector line 5", vec, 8'h25);
    rd_chk("R4 mask readback", 2'd0, 8'hDF);

    // R9 write-one-to-clear
    wr(2'd2, 8'h00);
    rd_chk("R9 zero write keeps", 2'd2, 8'h20);
    wr(2'd2, 8'h20);
    rd_chk("R9 one write clears", 2'd2, 8'h00);
    chk("R9 valid dropped", {7'b0, valid}, 8'h00);

    // table walk: priority, vectors, masks
    for (int k = 0; k < 10; k++) begin
      clean(TBL[k][31:24], TBL[k][23:16]);
      pri_line = TBL[k][47:40]; sec_line = TBL[k][39:32];
      tick();
      chk($sformatf("R5 table %0d valid", k), {7'b0, valid}, TBL[k][15:8]);
      if (TBL[k][8]) chk($sformatf("R6 table %0d vector", k), vec, TBL[k][7:0]);
    end

    // R7 transfer order and clears, R2 no retrigger on held level
    clean(8'h00, 8'h00);
    pri_line = 8'h03; sec_line = 8'h02; tick();
    chk("R7 first", vec, 8'h20);
    xfer();
    chk("R7 second", vec, 8'h21);
    xfer();
    chk("R7 third from secondary", vec, 8'h29);
    xfer();
    chk("R7 drained", {7'b0, valid}, 8'h00);
    tick();
    chk("R2 held level no retrigger", {7'b0, valid}, 8'h00);

    // R7 back-pressure
    clean(8'h00, 8'h00);
    pri_line = 8'h10; tick(); pri_line = 8'h00;
    repeat (3) tick();
    chk("R7 stable vector", vec, 8'h24);
    chk("R7 stable valid", {7'b0, valid}, 8'h01);

    // R8 cascade status
    clean(8'h00, 8'h00);
    sec_line = 8'h08; tick();
    rd_chk("R8 primary status bit 2", 2'd2, 8'h04);
    rd_chk("R8 secondary status", 2'd3, 8'h08);
    wr(2'd0, 8'h04);
    chk("R8 mask bit 2 blocks", {7'b0, valid}, 8'h00);

    // R10 edge and clear in same cycle
    clean(8'h00, 8'h00);
    pri_line = 8'h02; tick(); pri_line = 8'h00; tick();
    pri_line = 8'h02; addr = 2'd2; wdata = 8'h02; we = 1'b1;
    tick(); we = 1'b0;
    rd_chk("R10 edge wins over clear", 2'd2, 8'h02);

    summary();
  end
endmodule